// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a programmable logic array. It receives a vector of product terms from an AND plane and combines them with fixed OR logic. The resulting sum goes to the output pad either directly or through a storage element. Static configuration inputs choose four things:

- combinational or registered output;
- the storage element's behaviour: data, toggle, set/reset with hold, or J/K with toggle;
- what clocks the storage element: one of two shared bank clock pins, or a product term;
- how the pad driver is enabled.

Everything runs in one fast system clock domain. The selected clock source is an ordinary signal. The register advances only on a cycle where that source is high and was low on the previous cycle. A synchronous test load and a synchronous reset can both force the register. Two feedback paths return to the array. One comes from the pad and one from the register, so a buried register stays visible while its pad is turned around as an input.

Top module: `pal_macrocell`

## Requirements
- R1: While `rst` is high at a clock edge, the register and the edge-tracking state are cleared to 0. After the edge, `reg_fb` reads 0.
- R2: With `cfg_registered`=0, `pad_out` equals the OR of all unreserved product terms in the same cycle, with no clock edge in between.
- R3: With `cfg_registered`=1 and `cfg_ff_type`=0 (data), an active clock event loads the sum into the register. `pad_out` and `reg_fb` show the register value after that edge.
- R4: With `cfg_ff_type`=1 (toggle), an active clock event inverts the register when the sum is 1 and leaves it unchanged when the sum is 0.
- R5: With `cfg_ff_type`=2 (J/K), J is the OR of terms 0..3 and K is the OR of terms 4..7, after reserved terms are forced to 0. On an active event: J alone sets the register, K alone clears it, both toggle it, and neither holds it.
- R6: With `cfg_ff_type`=3 (set/reset), S is the OR of terms 0..3 and R is the OR of terms 4..7. On an active event: S alone sets the register, R alone clears it, and both or neither hold it.
- R7: `cfg_clk_src` selects the clock source: 0 is `bank_clk[0]`, 1 is `bank_clk[1]`, 2 is product term 7, and 3 is none. An active event is a system-clock edge at which the selected source is 1 and was 0 at the previous edge. Apart from reset and preload, the register changes only on active events.
- R8: With `cfg_clk_src`=2, term 7 is used only as the clock and is excluded from the sum and from the K/R group.
- R9: With `preload_en` high at an edge (and `rst` low), the register takes `preload_val`. This holds whether or not an active event occurs at that edge.
- R10: `cfg_oe_mode` controls `pad_oe`: 0 drives it to 1, 1 and 3 drive it to 0, and 2 makes it equal term 0. In mode 2, term 0 is excluded from the sum and from the J/S group.
- R11: `pin_fb` equals `pad_out` while `pad_oe` is 1, and equals `pad_in` otherwise. `reg_fb` always equals the register, even with the pad disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cfg_registered | input | 1 | 1 = pad driven from register, 0 = from the sum |
| cfg_ff_type | input | 2 | 0 data, 1 toggle, 2 J/K, 3 set/reset |
| cfg_clk_src | input | 2 | 0 bank 0, 1 bank 1, 2 product term 7, 3 none |
| cfg_oe_mode | input | 2 | 0 on, 1 off, 2 term 0, 3 off |
| pterm | input | NUM_PT | Product terms from the AND plane |
| bank_clk | input | 2 | Shared bank clock pins |
| preload_en | input | 1 | Test load strobe |
| preload_val | input | 1 | Test load value |
| pad_in | input | 1 | Level seen at the pad when not driven |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| pin_fb | output | 1 | Pad-side feedback to the array |
| reg_fb | output | 1 | Register-side feedback to the array |

## Verification
The pad value, the driver enable and the pin feedback depend combinationally on the inputs of the current cycle and on the register. The bench checks them 1 ns after it drives new inputs on the falling edge, well before the next rising edge. Register results show up one edge later. The bench samples them 1 ns after the rising edge at which reset, preload or an active clock event occurs, and updates its reference model at that same point. The model records whether the chosen clock source was 0 at the previous edge, so an active event is predicted at exactly the edge where the design sees one.

// File: rtl/pal_macrocell_pkg.sv
package pal_macrocell_pkg;
  typedef enum logic [1:0] {FF_DATA = 2'd0, FF_TOGGLE = 2'd1, FF_JK = 2'd2, FF_SR = 2'd3} ff_kind_e;
  typedef enum logic [1:0] {CS_BANK0 = 2'd0, CS_BANK1 = 2'd1, CS_PTERM = 2'd2, CS_NONE = 2'd3} clk_src_e;
  typedef enum logic [1:0] {OE_ON = 2'd0, OE_OFF = 2'd1, OE_PTERM = 2'd2, OE_OFF2 = 2'd3} oe_mode_e;
endpackage

// File: rtl/sop_combiner.sv
module sop_combiner #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] pterm,
  input  logic              reserve_oe,
  input  logic              reserve_clk,
  output logic              sum,
  output logic              grp_lo,
  output logic              grp_hi,
  output logic              oe_term,
  output logic              clk_term
);
  localparam int HALF = NUM_PT / 2;

  logic [NUM_PT-1:0] masked;

  // Reserved terms are forced to 0 before the OR planes.
  for (genvar i = 0; i < NUM_PT; i++) begin : g_mask
    if (i == 0) begin : g_first
      assign masked[i] = pterm[i] & ~reserve_oe;
    end else if (i == NUM_PT-1) begin : g_last
      assign masked[i] = pterm[i] & ~reserve_clk;
    end else begin : g_mid
      assign masked[i] = pterm[i];
    end
  end

  assign sum      = |masked;
  assign grp_lo   = |masked[HALF-1:0];
  assign grp_hi   = |masked[NUM_PT-1:HALF];
  assign oe_term  = pterm[0];
  assign clk_term = pterm[NUM_PT-1];
endmodule

// File: rtl/clk_event_detect.sv
module clk_event_detect
  import pal_macrocell_pkg::*;
#(
  parameter int NUM_BANK = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  clk_src_e            src,
  input  logic [NUM_BANK-1:0] bank_clk,
  input  logic                clk_term,
  output logic                tick
);
  logic sel;
  logic prev_q;

  always_comb begin
    unique case (src)
      CS_BANK0: sel = bank_clk[0];
      CS_BANK1: sel = bank_clk[NUM_BANK-1];
      CS_PTERM: sel = clk_term;
      default:  sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sel;
  end

  assign tick = sel & ~prev_q & ~rst;
endmodule

// File: rtl/macro_reg.sv
module macro_reg
  import pal_macrocell_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  ff_kind_e kind,
  input  logic     tick,
  input  logic     sum,
  input  logic     grp_lo,
  input  logic     grp_hi,
  input  logic     preload_en,
  input  logic     preload_val,
  output logic     q
);
  logic nxt;

  always_comb begin
    unique case (kind)
      FF_DATA:   nxt = sum;
      FF_TOGGLE: nxt = q ^ sum;
      FF_JK:     nxt = (grp_lo & grp_hi) ? ~q : (grp_lo ? 1'b1 : (grp_hi ? 1'b0 : q));
      default:   nxt = (grp_lo & ~grp_hi) ? 1'b1 : ((grp_hi & ~grp_lo) ? 1'b0 : q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else if (tick)       q <= nxt;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (q == 1'b0));

  // R9
  preload_wins_chk: assert property (@(posedge clk) disable iff (rst)
    preload_en |=> (q == $past(preload_val)));

  // R7
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && !tick) |=> $stable(q));

  // R3
  data_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && tick && kind == FF_DATA) |=> (q == $past(sum)));

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && tick && kind == FF_TOGGLE && sum) |=> (q != $past(q)));

  // R6
  sr_both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!preload_en && tick && kind == FF_SR && grp_lo && grp_hi) |=> $stable(q));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_macrocell_pkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_registered,
  input  logic [1:0]        cfg_ff_type,
  input  logic [1:0]        cfg_clk_src,
  input  logic [1:0]        cfg_oe_mode,
  input  logic [NUM_PT-1:0] pterm,
  input  logic [1:0]        bank_clk,
  input  logic              preload_en,
  input  logic              preload_val,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pin_fb,
  output logic              reg_fb
);
  localparam int NUM_BANK = 2;

  ff_kind_e kind;
  clk_src_e src;
  oe_mode_e oe_mode;
  logic sum, grp_lo, grp_hi, oe_term, clk_term, tick, q;

  assign kind    = ff_kind_e'(cfg_ff_type);
  assign src     = clk_src_e'(cfg_clk_src);
  assign oe_mode = oe_mode_e'(cfg_oe_mode);

  sop_combiner #(.NUM_PT(NUM_PT)) u_sop (
    .pterm       (pterm),
    .reserve_oe  (oe_mode == OE_PTERM),
    .reserve_clk (src == CS_PTERM),
    .sum         (sum),
    .grp_lo      (grp_lo),
    .grp_hi      (grp_hi),
    .oe_term     (oe_term),
    .clk_term    (clk_term)
  );

  clk_event_detect #(.NUM_BANK(NUM_BANK)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .bank_clk (bank_clk),
    .clk_term (clk_term),
    .tick     (tick)
  );

  macro_reg u_reg (
    .clk         (clk),
    .rst         (rst),
    .kind        (kind),
    .tick        (tick),
    .sum         (sum),
    .grp_lo      (grp_lo),
    .grp_hi      (grp_hi),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .q           (q)
  );

  always_comb begin
    unique case (oe_mode)
      OE_ON:    pad_oe = 1'b1;
      OE_PTERM: pad_oe = oe_term;
      default:  pad_oe = 1'b0;
    endcase
  end

  assign pad_out = cfg_registered ? q : sum;
  assign pin_fb  = pad_oe ? pad_out : pad_in;
  assign reg_fb  = q;

  // R11
  buried_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_registered && !preload_en && !tick) |=> (reg_fb == $past(reg_fb)));

  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe_mode == 2'd1) |-> !pad_oe);
endmodule

// File: tb/pal_macrocell_test.sv
`timescale 1ns/1ps
module pal_macrocell_test;
  localparam int NUM_PT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_registered = 1'b0;
  logic [1:0] cfg_ff_type = 2'd0, cfg_clk_src = 2'd0, cfg_oe_mode = 2'd0;
  logic [NUM_PT-1:0] pterm = '0;
  logic [1:0] bank_clk = 2'b00;
  logic preload_en = 1'b0, preload_val = 1'b0, pad_in = 1'b0;
  logic pad_out, pad_oe, pin_fb, reg_fb;

  int checks = 0, fails = 0;
  logic m_q = 1'b0, m_prev = 1'b0;

  always #2.5 clk = ~clk;

  pal_macrocell #(.NUM_PT(NUM_PT)) uut (
    .clk(clk), .rst(rst), .cfg_registered(cfg_registered), .cfg_ff_type(cfg_ff_type),
    .cfg_clk_src(cfg_clk_src), .cfg_oe_mode(cfg_oe_mode), .pterm(pterm), .bank_clk(bank_clk),
    .preload_en(preload_en), .preload_val(preload_val), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pin_fb(pin_fb), .reg_fb(reg_fb));

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NUM_PT-1:0] masked_terms(input logic [NUM_PT-1:0] p);
    logic [NUM_PT-1:0] m = p;
    if (cfg_oe_mode == 2'd2) m[0] = 1'b0;
    if (cfg_clk_src == 2'd2) m[NUM_PT-1] = 1'b0;
    return m;
  endfunction

  function automatic logic exp_oe(input logic [NUM_PT-1:0] p);
    case (cfg_oe_mode)
      2'd0: return 1'b1;
      2'd2: return p[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_sel(input logic [NUM_PT-1:0] p, input logic [1:0] b);
    case (cfg_clk_src)
      2'd0: return b[0];
      2'd1: return b[1];
      2'd2: return p[NUM_PT-1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_next(input logic q, input logic [NUM_PT-1:0] p);
    logic [NUM_PT-1:0] m = masked_terms(p);
    logic s = |m, a = |m[3:0], b = |m[7:4];
    case (cfg_ff_type)
      2'd0: return s;
      2'd1: return q ^ s;
      2'd2: return (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
      default: return (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
    endcase
  endfunction

  function automatic string kind_tag();
    case (cfg_ff_type)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic r, input logic [NUM_PT-1:0] p, input logic [1:0] b,
                      input logic pe, input logic pv, input logic pin, input string tag);
    logic eo, ep, sel, tk;
    @(negedge clk);
    rst = r; pterm = p; bank_clk = b; preload_en = pe; preload_val = pv; pad_in = pin;
    #1;
    eo = exp_oe(p);
    ep = cfg_registered ? m_q : |masked_terms(p);
    check(cfg_registered ? kind_tag() : "R2", {tag, " pad_out"}, pad_out, ep);
    check("R10", {tag, " pad_oe"}, pad_oe, eo);
    check("R11", {tag, " pin_fb"}, pin_fb, eo ? ep : pin);
    sel = exp_sel(p, b);
    tk = sel & ~m_prev;
    @(posedge clk);
    #1;
    if (r) begin m_q = 1'b0; m_prev = 1'b0; end
    else begin
      if (pe) m_q = pv;
      else if (tk) m_q = exp_next(m_q, p);
      m_prev = sel;
    end
    check(r ? "R1" : (pe ? "R9" : kind_tag()), {tag, " reg_fb"}, reg_fb, m_q);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    // R1: reset state
    step(1'b1, '0, 2'b00, 1'b0, 1'b0, 1'b0, "R1 reset");
    check("R1", "reg_fb after reset", reg_fb, 1'b0);
    // R2: combinational sum
    cfg_registered = 0; cfg_oe_mode = 0; cfg_clk_src = 3;
    step(0, 8'h00, 0, 0, 0, 0, "R2 none");
    step(0, 8'h40, 0, 0, 0, 0, "R2 one");
    // R3 + R7: data on bank0 rising edge only
    cfg_registered = 1; cfg_ff_type = 0; cfg_clk_src = 0;
    step(0, 8'h01, 2'b01, 0, 0, 0, "R7 rise");
    check("R3", "data loaded", reg_fb, 1'b1);
    step(0, 8'h00, 2'b01, 0, 0, 0, "R7 high no edge");
    check("R7", "held without edge", reg_fb, 1'b1);
    step(0, 8'h00, 2'b10, 0, 0, 0, "R7 other bank");
    check("R7", "other bank ignored", reg_fb, 1'b1);
    // R4 toggle
    cfg_ff_type = 1;
    step(0, 8'h08, 2'b01, 0, 0, 0, "R4 toggle");
    check("R4", "toggled", reg_fb, 1'b0);
    // R5 J/K both -> toggle
    cfg_ff_type = 2;
    step(0, 8'h00, 2'b00, 0, 0, 0, "R5 low");
    step(0, 8'h11, 2'b01, 0, 0, 0, "R5 both");
    check("R5", "JK both toggles", reg_fb, 1'b1);
    // R6 S/R both -> hold
    cfg_ff_type = 3;
    step(0, 8'h22, 2'b00, 0, 0, 0, "R6 low");
    step(0, 8'h22, 2'b01, 0, 0, 0, "R6 both");
    check("R6", "SR both holds", reg_fb, 1'b1);
    step(0, 8'h20, 2'b00, 0, 0, 0, "R6 low2");
    step(0, 8'h20, 2'b01, 0, 0, 0, "R6 reset");
    check("R6", "R alone clears", reg_fb, 1'b0);
    // R8: product-term clock, term 7 excluded
    cfg_ff_type = 0; cfg_clk_src = 2;
    step(0, 8'h00, 0, 0, 0, 0, "R8 low");
    step(0, 8'h80, 0, 0, 0, 0, "R8 clock only");
    check("R8", "term7 not in sum", reg_fb, 1'b0);
    // R9: preload beats a clock event
    step(0, 8'h00, 0, 0, 0, 0, "R9 low");
    step(0, 8'h80, 0, 1, 1, 0, "R9 preload");
    check("R9", "preload wins", reg_fb, 1'b1);
    // R10/R11: pad off, register still fed back
    cfg_oe_mode = 1;
    step(0, 8'h00, 0, 0, 0, 0, "R11 buried");
    check("R11", "buried reg_fb", reg_fb, 1'b1);
    check("R11", "pin_fb from pad_in", pin_fb, 1'b0);
    cfg_oe_mode = 2;
    step(0, 8'h01, 0, 0, 0, 1, "R10 term0 oe");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 15) == 0) begin
        cfg_registered = 1'($urandom); cfg_ff_type = 2'($urandom);
        cfg_clk_src = 2'($urandom); cfg_oe_mode = 2'($urandom);
      end
      step($urandom_range(0, 99) == 0, 8'($urandom), 2'($urandom),
           $urandom_range(0, 19) == 0, 1'($urandom), 1'($urandom), "random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule